// File: doc/BRIEF.md
# Monostable Pulse Timer with Settling Code Filter

This block is a one-shot pulse generator running from a master clock. A short parallel code word, delivered by an external converter, selects the pulse width: the width in clock periods is a base count shifted left by three bit positions per code step. A rising edge on the trigger input launches one output pulse of the currently selected width. The output level while idle follows the polarity input, and the pulse drives the opposite level.

After reset, a start-up window runs for a fixed number of clock periods. During this window the output stays low and every trigger is discarded. When the window closes, the block captures the code word and moves the output to its idle level.

From then on, a settling filter guards the code word. A new value is adopted only after it has held steady for a time that grows with the distance between the new value and the one in use. When it is adopted, the effective code jumps straight to the new value and never passes through the codes in between. A pulse already running when a new code is adopted may end at a width between the two settings. Only the pulses launched afterwards are sure to use the new width.

Top module: `oneshot_timer`

## Requirements
- R1: For START_CYC clock periods after reset is released, `pulse_o` is held low whatever the other inputs do.
- R2: Trigger edges arriving during the start-up window produce no pulse, either then or afterwards.
- R3: On the clock edge that ends the start-up window, the code word is captured and `pulse_o` moves to the idle level: high when `pol_i` is 1 and low when `pol_i` is 0.
- R4: After start-up, each accepted trigger produces one pulse at the level opposite to idle. The pulse lasts exactly BASE_CNT << (3 × code) clock periods, where code is the unsigned value on `code_i`.
- R5: `trig_i` passes through a two-stage synchronizer and a rising-edge detector. The pulse level first appears after the third rising clock edge at which `trig_i` is sampled high.
- R6: A rising trigger edge seen while a pulse is active is ignored. It neither extends the pulse nor queues another one.
- R7: After start-up, a changed code takes effect only once it has stayed unchanged for 16 × (|new − old| + 6) clock periods. Pulses launched before then use the old width.
- R8: If `code_i` changes again while a candidate code is settling, the settle count restarts, and the newest value becomes the candidate.
- R9: The effective code moves from the old value directly to the accepted value and never takes any intermediate code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| code_i | input | CODE_W | Raw divider code from the external converter |
| pol_i | input | 1 | Idle level of the output after start-up (pulse is its inverse) |
| trig_i | input | 1 | Asynchronous trigger; rising edges launch pulses |
| pulse_o | output | 1 | Pulse output |

## Verification
Each result has a due time. The output must be at its idle level at the negative edge that follows clock edge START_CYC after reset release, and it must be low at every earlier sample. A trigger raised just after a clock edge shows up on the output after the third following edge and not after the second, and the bench samples both of those points. Code changes need longer waits, so the bench does not sample them at one exact edge. It launches triggers well inside or well past the settle window 16 × (|Δ| + 6), then lets a monitor measure each pulse width and compare it with the width queued by the driver.

// File: rtl/osht_pkg.sv
package osht_pkg;

   // Settle time, in clock periods, for a code step of the given size.
   function automatic int unsigned settle_cycles(input int unsigned step,
                                                 input int unsigned unit,
                                                 input int unsigned bias);
      return unit * (step + bias);
   endfunction

   // Bit count needed to hold a value up to 'v'.
   function automatic int unsigned bits_for(input int unsigned v);
      return (v < 2) ? 1 : $clog2(v + 1);
   endfunction

endpackage

// File: rtl/osht_startup.sv
module osht_startup #(
   parameter int unsigned START_CYC = 500
) (
   input  logic clk,
   input  logic rst_n,
   output logic done_o,
   output logic fire_o
);
   localparam int unsigned SW = osht_pkg::bits_for(START_CYC);

   logic [SW-1:0] cnt_q;
   logic          done_q;

   assign fire_o = !done_q && (cnt_q == SW'(START_CYC - 1));
   assign done_o = done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         done_q <= 1'b0;
      end else if (!done_q) begin
         if (fire_o) done_q <= 1'b1;
         else        cnt_q  <= cnt_q + SW'(1);
      end
   end
endmodule

// File: rtl/osht_code_filter.sv
module osht_code_filter #(
   parameter int unsigned CODE_W      = 3,
   parameter int unsigned SETTLE_UNIT = 16,
   parameter int unsigned SETTLE_BIAS = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              capture_i,
   input  logic              run_i,
   input  logic [CODE_W-1:0] raw_i,
   output logic [CODE_W-1:0] eff_o,
   output logic [CODE_W-1:0] cand_o
);
   localparam int unsigned MAX_LIM = osht_pkg::settle_cycles((1 << CODE_W) - 1,
                                                             SETTLE_UNIT, SETTLE_BIAS);
   localparam int unsigned CW      = osht_pkg::bits_for(MAX_LIM);

   logic [CODE_W-1:0] eff_q, cand_q, step;
   logic [CW-1:0]     cnt_q, limit;

   assign step  = (cand_q > eff_q) ? (cand_q - eff_q) : (eff_q - cand_q);
   assign limit = CW'(osht_pkg::settle_cycles(int'(step), SETTLE_UNIT, SETTLE_BIAS));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         eff_q  <= '0;
         cand_q <= '0;
         cnt_q  <= '0;
      end else if (capture_i) begin
         eff_q  <= raw_i;
         cand_q <= raw_i;
         cnt_q  <= '0;
      end else if (run_i) begin
         if (raw_i != cand_q) begin
            cand_q <= raw_i;
            cnt_q  <= '0;
         end else if (cand_q != eff_q) begin
            if (cnt_q == limit - CW'(1)) begin
               eff_q <= cand_q;
               cnt_q <= '0;
            end else begin
               cnt_q <= cnt_q + CW'(1);
            end
         end else begin
            cnt_q <= '0;
         end
      end
   end

   assign eff_o  = eff_q;
   assign cand_o = cand_q;
endmodule

// File: rtl/osht_pulse.sv
module osht_pulse #(
   parameter int unsigned CODE_W      = 3,
   parameter int unsigned BASE_CNT    = 1,
   parameter int unsigned SHIFT_STEP  = 3,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en_i,
   input  logic              pol_i,
   input  logic              trig_i,
   input  logic [CODE_W-1:0] code_i,
   output logic              out_o,
   output logic              active_o,
   output logic              edge_o
);
   localparam int unsigned PW = osht_pkg::bits_for(BASE_CNT)
                              + SHIFT_STEP * ((1 << CODE_W) - 1);

   logic          sh_q [SYNC_STAGES+1];
   logic [PW-1:0] width, cnt_q;
   logic          active_q;

   for (genvar i = 0; i <= SYNC_STAGES; i++) begin : g_sync
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh_q[i] <= 1'b0;
            else        sh_q[i] <= trig_i;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh_q[i] <= 1'b0;
            else        sh_q[i] <= sh_q[i-1];
         end
      end
   end

   assign edge_o = sh_q[SYNC_STAGES-1] & ~sh_q[SYNC_STAGES];
   assign width  = PW'(BASE_CNT) << (SHIFT_STEP * int'(code_i));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         cnt_q    <= '0;
      end else if (!en_i) begin
         active_q <= 1'b0;
         cnt_q    <= '0;
      end else if (active_q) begin
         if (cnt_q >= width - PW'(1)) begin
            active_q <= 1'b0;
            cnt_q    <= '0;
         end else begin
            cnt_q <= cnt_q + PW'(1);
         end
      end else if (edge_o) begin
         active_q <= 1'b1;
         cnt_q    <= '0;
      end
   end

   assign active_o = active_q;
   assign out_o    = en_i & (pol_i ^ active_q);
endmodule

// File: rtl/oneshot_timer.sv
module oneshot_timer #(
   parameter int unsigned CODE_W      = 3,
   parameter int unsigned BASE_CNT    = 1,
   parameter int unsigned SHIFT_STEP  = 3,
   parameter int unsigned START_CYC   = 500,
   parameter int unsigned SETTLE_UNIT = 16,
   parameter int unsigned SETTLE_BIAS = 6,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CODE_W-1:0] code_i,
   input  logic              pol_i,
   input  logic              trig_i,
   output logic              pulse_o
);
   if (CODE_W < 1 || CODE_W > 4) begin : g_bad_code
      $error("oneshot_timer: CODE_W out of range");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("oneshot_timer: SYNC_STAGES must be at least 2");
   end
   if (START_CYC < 1 || BASE_CNT < 1 || SETTLE_UNIT < 1) begin : g_bad_count
      $error("oneshot_timer: counts must be nonzero");
   end

   logic              started, start_fire;
   logic              active, edge_seen;
   logic [CODE_W-1:0] eff_code, cand_code;

   osht_startup #(.START_CYC(START_CYC)) u_start (
      .clk    (clk),
      .rst_n  (rst_n),
      .done_o (started),
      .fire_o (start_fire)
   );

   osht_code_filter #(
      .CODE_W      (CODE_W),
      .SETTLE_UNIT (SETTLE_UNIT),
      .SETTLE_BIAS (SETTLE_BIAS)
   ) u_filt (
      .clk       (clk),
      .rst_n     (rst_n),
      .capture_i (start_fire),
      .run_i     (started),
      .raw_i     (code_i),
      .eff_o     (eff_code),
      .cand_o    (cand_code)
   );

   osht_pulse #(
      .CODE_W      (CODE_W),
      .BASE_CNT    (BASE_CNT),
      .SHIFT_STEP  (SHIFT_STEP),
      .SYNC_STAGES (SYNC_STAGES)
   ) u_pulse (
      .clk      (clk),
      .rst_n    (rst_n),
      .en_i     (started),
      .pol_i    (pol_i),
      .trig_i   (trig_i),
      .code_i   (eff_code),
      .out_o    (pulse_o),
      .active_o (active),
      .edge_o   (edge_seen)
   );
endmodule

// File: rtl/oneshot_timer_chk.sv
module oneshot_timer_chk #(
   parameter int unsigned CODE_W = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic [CODE_W-1:0] code_i,
   input logic              pulse_o,
   input logic              started,
   input logic              active,
   input logic              edge_seen,
   input logic [CODE_W-1:0] eff_code,
   input logic [CODE_W-1:0] cand_code
);
   // R1
   startup_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !started |-> (pulse_o == 1'b0));

   // R2
   startup_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !started |-> !active);

   // R3
   capture_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(started) |-> (eff_code == $past(code_i)));

   // R5
   launch_from_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(active) |-> $past(edge_seen));

   // R9
   direct_jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(eff_code) && $past(started)) |-> (eff_code == $past(cand_code)));
endmodule

bind oneshot_timer oneshot_timer_chk #(.CODE_W(CODE_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .code_i    (code_i),
   .pulse_o   (pulse_o),
   .started   (started),
   .active    (active),
   .edge_seen (edge_seen),
   .eff_code  (eff_code),
   .cand_code (cand_code)
);

// File: tb/sim_oneshot_timer.sv
module sim_oneshot_timer;
   localparam int CODE_W = 3;
   localparam int BASE   = 2;
   localparam int START  = 500;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [CODE_W-1:0] code_i = '0;
   logic              pol_i = 1'b0;
   logic              trig_i = 1'b0;
   logic              pulse_o;

   int total_n = 0, fail_n = 0;
   int exp_q[$];
   int exp_req[$];
   bit mon_en = 1'b0;
   int run_len = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   oneshot_timer #(.CODE_W(CODE_W), .BASE_CNT(BASE), .START_CYC(START)) u0 (
      .clk(clk), .rst_n(rst_n), .code_i(code_i), .pol_i(pol_i),
      .trig_i(trig_i), .pulse_o(pulse_o)
   );

   function automatic int wfor(input int c);
      return BASE << (3 * c);
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      total_n++;
      if (!ok) begin
         fail_n++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Monitor: measure each pulse and compare with the queued width.
   always @(negedge clk) begin
      if (mon_en) begin
         if (pulse_o != pol_i) begin
            run_len++;
         end else if (run_len > 0) begin
            if (exp_q.size() == 0) begin
               check(1'b0, "R2/R6 unexpected pulse", run_len, 0);
            end else begin
               int e, r;
               e = exp_q.pop_front();
               r = exp_req.pop_front();
               check(run_len == e, $sformatf("R%0d pulse width", r), run_len, e);
            end
            run_len = 0;
         end
      end
   end

   task automatic do_reset(input bit pol, input logic [CODE_W-1:0] code);
      mon_en = 1'b0;
      @(negedge clk);
      rst_n  = 1'b0;
      pol_i  = pol;
      code_i = code;
      trig_i = 1'b0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
   endtask

   // Driver: queue the expected width, raise the trigger, wait for the pulse.
   task automatic fire(input int width, input int req);
      exp_q.push_back(width);
      exp_req.push_back(req);
      @(negedge clk);
      trig_i = 1'b1;
      repeat (4) @(negedge clk);
      trig_i = 1'b0;
      repeat (width + 8) @(negedge clk);
   endtask

   initial begin
      #(4 * 200000);
      if (!finished) begin
         check(1'b0, "watchdog", 0, 1);
         $display("%0d/%0d checks passed", total_n - fail_n, total_n);
         $finish;
      end
   end

   initial begin
      int high_seen;
      // ---- start-up with pol=1, code=1 ----
      do_reset(1'b1, 3'd1);
      high_seen = 0;
      for (int k = 1; k < START; k++) begin
         @(negedge clk);
         if (pulse_o) high_seen++;
         // R2: trigger during start-up window
         if (k == 100) trig_i = 1'b1;
         if (k == 104) trig_i = 1'b0;
         if (k == 480) trig_i = 1'b1;
         if (k == 484) trig_i = 1'b0;
      end
      check(high_seen == 0, "R1 output low in start-up", high_seen, 0);
      @(negedge clk);
      check(pulse_o == 1'b1, "R3 idle high at end of start-up (pol=1)", pulse_o, 1);
      mon_en = 1'b1;
      repeat (20) @(negedge clk);
      check(pulse_o == 1'b1, "R2 no late pulse from start-up triggers", pulse_o, 1);

      // ---- R5 latency, code 1 -> width 16 ----
      exp_q.push_back(wfor(1));
      exp_req.push_back(5);
      @(negedge clk);
      trig_i = 1'b1;
      @(negedge clk);
      @(negedge clk);
      check(pulse_o == 1'b1, "R5 not active after two edges", pulse_o, 1);
      @(negedge clk);
      check(pulse_o == 1'b0, "R5 active after third edge", pulse_o, 0);
      @(negedge clk);
      trig_i = 1'b0;
      repeat (wfor(1) + 8) @(negedge clk);

      // R4 plain pulse
      fire(wfor(1), 4);

      // R6: second rising edge during active pulse
      exp_q.push_back(wfor(1));
      exp_req.push_back(6);
      @(negedge clk);
      trig_i = 1'b1;
      repeat (3) @(negedge clk);
      trig_i = 1'b0;
      repeat (3) @(negedge clk);
      trig_i = 1'b1;
      repeat (3) @(negedge clk);
      trig_i = 1'b0;
      repeat (wfor(1) + 20) @(negedge clk);

      // ---- start-up with pol=0, code=0 ----
      do_reset(1'b0, 3'd0);
      repeat (START) @(negedge clk);
      check(pulse_o == 1'b0, "R3 idle low at end of start-up (pol=0)", pulse_o, 0);
      mon_en = 1'b1;
      fire(wfor(0), 4);

      // R7: 0 -> 2, settle 128
      code_i = 3'd2;
      repeat (60) @(negedge clk);
      fire(wfor(0), 7);
      repeat (100) @(negedge clk);
      fire(wfor(2), 7);

      // R9: 2 -> 0 (settle 128), then 0 -> 3 (settle 144)
      code_i = 3'd0;
      repeat (200) @(negedge clk);
      code_i = 3'd3;
      repeat (150) @(negedge clk);
      fire(wfor(3), 9);

      // R8: back to 0, then 0 -> 2 interrupted by 1
      code_i = 3'd0;
      repeat (200) @(negedge clk);
      code_i = 3'd2;
      repeat (100) @(negedge clk);
      code_i = 3'd1;
      repeat (60) @(negedge clk);
      fire(wfor(0), 8);
      repeat (100) @(negedge clk);
      fire(wfor(1), 8);

      repeat (10) @(negedge clk);
      check(exp_q.size() == 0, "R4 all expected pulses seen", exp_q.size(), 0);

      finished = 1'b1;
      $display("%0d/%0d checks passed", total_n - fail_n, total_n);
      $finish;
   end
endmodule